// File: doc/BRIEF.md
# Bimodal Direction Predictor with Group-Shared Confidence

This block predicts whether a conditional branch is taken. Its state is equivalent to a table of two-bit saturating predictors, which hold a direction and a strong/weak confidence. The state is stored as two separate bit tables. The direction table holds one taken/not-taken bit for each entry. The confidence table is smaller: each of its bits is shared by a group of `SHARE` adjacent direction entries. For a fixed number of storage bits, the predictor therefore tracks more distinct branches than a table of two-bit counters.

The fetch stage puts a branch address on the lookup port. The direction and the confidence for that address come back combinationally in the same cycle. When the branch resolves, the back end presents the branch address and the actual outcome on the update port. The tables change at the next clock edge according to a fixed hysteresis rule. The prediction that the rule compares against is the direction bit currently stored for the branch.

Top module: `shbp_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after release, every direction bit reads not-taken (0) and every confidence bit reads weak (0).
- R2: The predicted direction is the direction bit at index `pc[PC_LSB +: log2(DIR_ENTRIES)]`. Address bits below `PC_LSB` and above the index field do not affect the result.
- R3: The confidence output is the confidence bit at the direction index shifted right by log2(`SHARE`). Confidence 1 means strong.
- R4: If an update's outcome equals the stored direction bit, the shared confidence bit becomes strong and the direction bit is left unchanged.
- R5: If an update's outcome differs from the stored direction bit and the shared confidence is strong, the confidence becomes weak and the direction bit is left unchanged.
- R6: If an update's outcome differs from the stored direction bit and the shared confidence is weak, the direction bit is inverted and the confidence becomes strong.
- R7: When a lookup and an update hit the same entry in the same cycle, the lookup returns the value from before the update.
- R8: An update changes the confidence seen by every entry in the updated entry's group. It changes no direction bit other than the updated entry's own.
- R9: A cycle in which `upd_valid` is low changes neither table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_strong | output | 1 | Shared confidence for the looked-up entry, 1 = strong |
| upd_valid | input | 1 | Resolved-branch update present this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench builds the block with an 8-bit address, 16 direction entries, a sharing factor of 4 and an index that starts at bit 2. With these values every direction bit and every confidence bit can be read back through the lookup port in a 16-entry sweep. The random addresses also drive the two bits above the index field and the two bits below it, so the address bits that must be ignored are exercised. A bench-side model of the two tables follows thousands of pseudo-random updates. After every 16 updates the bench sweeps the whole table and compares it against the model. Each update is also looked up in the same cycle to check that the pre-update value is returned.

// File: rtl/shbp_pkg.sv
package shbp_pkg;

   typedef enum logic {
      CONF_WEAK   = 1'b0,
      CONF_STRONG = 1'b1
   } conf_e;

   typedef struct packed {
      logic  dir_we;
      logic  dir_val;
      logic  conf_we;
      conf_e conf_val;
   } upd_cmd_t;

   // Hysteresis rule applied to one resolved branch.
   function automatic upd_cmd_t shbp_decide(
      input logic  valid,
      input logic  cur_dir,
      input conf_e cur_conf,
      input logic  outcome
   );
      upd_cmd_t c;
      c.dir_we   = 1'b0;
      c.dir_val  = cur_dir;
      c.conf_we  = 1'b0;
      c.conf_val = cur_conf;
      if (valid) begin
         c.conf_we = 1'b1;
         if (cur_dir == outcome) begin
            c.conf_val = CONF_STRONG;
         end else if (cur_conf == CONF_STRONG) begin
            c.conf_val = CONF_WEAK;
         end else begin
            c.dir_we   = 1'b1;
            c.dir_val  = ~cur_dir;
            c.conf_val = CONF_STRONG;
         end
      end
      return c;
   endfunction

endpackage

// File: rtl/shbp_index.sv
module shbp_index #(
   parameter int PC_W       = 32,
   parameter int PC_LSB     = 2,
   parameter int DIR_IDX_W  = 8,
   parameter int CONF_IDX_W = 6
) (
   input  logic [PC_W-1:0]       pc,
   output logic [DIR_IDX_W-1:0]  dir_idx,
   output logic [CONF_IDX_W-1:0] conf_idx
);

   assign dir_idx = pc[PC_LSB +: DIR_IDX_W];

   generate
      if (CONF_IDX_W == DIR_IDX_W) begin : g_no_share
         assign conf_idx = dir_idx;
      end else begin : g_share
         assign conf_idx = dir_idx[DIR_IDX_W-1 -: CONF_IDX_W];
      end
   endgenerate

endmodule

// File: rtl/shbp_bit_table.sv
module shbp_bit_table #(
   parameter int   ENTRIES = 256,
   parameter int   IDX_W   = 8,
   parameter logic RST_VAL = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [IDX_W-1:0]   rd_a_idx,
   output logic               rd_a,
   input  logic [IDX_W-1:0]   rd_b_idx,
   output logic               rd_b,
   input  logic               we,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic               wr_val,
   output logic [ENTRIES-1:0] bits
);

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_cell
         logic hit;
         assign hit = we && (wr_idx == IDX_W'(e));
         always_ff @(posedge clk) begin
            if (!rst_n)   bits[e] <= RST_VAL;
            else if (hit) bits[e] <= wr_val;
         end
      end
   endgenerate

   assign rd_a = bits[rd_a_idx];
   assign rd_b = bits[rd_b_idx];

endmodule

// File: rtl/shbp_update_ctl.sv
module shbp_update_ctl
   import shbp_pkg::*;
(
   input  logic     upd_valid,
   input  logic     upd_taken,
   input  logic     cur_dir,
   input  logic     cur_conf,
   output upd_cmd_t cmd
);

   conf_e conf_now;
   assign conf_now = conf_e'(cur_conf);
   assign cmd      = shbp_decide(upd_valid, cur_dir, conf_now, upd_taken);

endmodule

// File: rtl/shbp_top.sv
module shbp_top
   import shbp_pkg::*;
#(
   parameter int PC_W        = 32,
   parameter int PC_LSB      = 2,
   parameter int DIR_ENTRIES = 256,
   parameter int SHARE       = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   output logic            pred_taken,
   output logic            pred_strong,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken
);

   localparam int DIR_IDX_W    = $clog2(DIR_ENTRIES);
   localparam int SHARE_W      = $clog2(SHARE);
   localparam int CONF_ENTRIES = DIR_ENTRIES / SHARE;
   localparam int CONF_IDX_W   = DIR_IDX_W - SHARE_W;

   generate
      if ((1 << DIR_IDX_W) != DIR_ENTRIES || DIR_ENTRIES < 2) begin : g_bad_depth
         $error("DIR_ENTRIES must be a power of two of at least 2");
      end
      if ((1 << SHARE_W) != SHARE || SHARE >= DIR_ENTRIES) begin : g_bad_share
         $error("SHARE must be a power of two below DIR_ENTRIES");
      end
      if (PC_W < PC_LSB + DIR_IDX_W) begin : g_bad_pc
         $error("PC_W too narrow for index field");
      end
   endgenerate

   logic [DIR_IDX_W-1:0]    lk_dir_idx, up_dir_idx;
   logic [CONF_IDX_W-1:0]   lk_conf_idx, up_conf_idx;
   logic                    up_dir_cur, up_conf_cur;
   logic [DIR_ENTRIES-1:0]  dir_bits;
   logic [CONF_ENTRIES-1:0] conf_bits;
   upd_cmd_t                cmd;

   shbp_index #(
      .PC_W(PC_W), .PC_LSB(PC_LSB),
      .DIR_IDX_W(DIR_IDX_W), .CONF_IDX_W(CONF_IDX_W)
   ) u_lk_idx (
      .pc(lk_pc), .dir_idx(lk_dir_idx), .conf_idx(lk_conf_idx)
   );

   shbp_index #(
      .PC_W(PC_W), .PC_LSB(PC_LSB),
      .DIR_IDX_W(DIR_IDX_W), .CONF_IDX_W(CONF_IDX_W)
   ) u_up_idx (
      .pc(upd_pc), .dir_idx(up_dir_idx), .conf_idx(up_conf_idx)
   );

   shbp_bit_table #(
      .ENTRIES(DIR_ENTRIES), .IDX_W(DIR_IDX_W), .RST_VAL(1'b0)
   ) u_dir_tbl (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(lk_dir_idx), .rd_a(pred_taken),
      .rd_b_idx(up_dir_idx), .rd_b(up_dir_cur),
      .we(cmd.dir_we), .wr_idx(up_dir_idx), .wr_val(cmd.dir_val),
      .bits(dir_bits)
   );

   shbp_bit_table #(
      .ENTRIES(CONF_ENTRIES), .IDX_W(CONF_IDX_W), .RST_VAL(1'b0)
   ) u_conf_tbl (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(lk_conf_idx), .rd_a(pred_strong),
      .rd_b_idx(up_conf_idx), .rd_b(up_conf_cur),
      .we(cmd.conf_we), .wr_idx(up_conf_idx), .wr_val(cmd.conf_val),
      .bits(conf_bits)
   );

   shbp_update_ctl u_ctl (
      .upd_valid(upd_valid), .upd_taken(upd_taken),
      .cur_dir(up_dir_cur), .cur_conf(up_conf_cur),
      .cmd(cmd)
   );

endmodule

// File: rtl/shbp_checker.sv
module shbp_checker #(
   parameter int PC_W        = 32,
   parameter int PC_LSB      = 2,
   parameter int DIR_ENTRIES = 256,
   parameter int SHARE       = 4
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        upd_valid,
   input logic [PC_W-1:0]             upd_pc,
   input logic                        upd_taken,
   input logic [DIR_ENTRIES-1:0]      dir_bits,
   input logic [DIR_ENTRIES/SHARE-1:0] conf_bits
);

   localparam int DIR_IDX_W  = $clog2(DIR_ENTRIES);
   localparam int CONF_IDX_W = DIR_IDX_W - $clog2(SHARE);

   logic [DIR_IDX_W-1:0]  ui, ui_q;
   logic [CONF_IDX_W-1:0] ci, ci_q;
   logic uv_q, hit_q, strong_q, dir_old_q, rst_d;

   assign ui = upd_pc[PC_LSB +: DIR_IDX_W];
   assign ci = CONF_IDX_W'(ui >> (DIR_IDX_W - CONF_IDX_W));

   always_ff @(posedge clk) begin
      rst_d <= rst_n;
      if (!rst_n) begin
         uv_q <= 1'b0; ui_q <= '0; ci_q <= '0;
         hit_q <= 1'b0; strong_q <= 1'b0; dir_old_q <= 1'b0;
      end else begin
         uv_q      <= upd_valid;
         ui_q      <= ui;
         ci_q      <= ci;
         hit_q     <= (dir_bits[ui] == upd_taken);
         strong_q  <= conf_bits[ci];
         dir_old_q <= dir_bits[ui];
      end
   end

   always @(posedge clk) begin
      if (rst_n && !rst_d) begin
         assert_reset_clear_R1: assert (dir_bits == '0 && conf_bits == '0);
      end
   end

   assert_correct_strong_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (uv_q && hit_q) |-> (conf_bits[ci_q] && dir_bits[ui_q] == dir_old_q));

   assert_miss_weaken_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (uv_q && !hit_q && strong_q) |-> (!conf_bits[ci_q] && dir_bits[ui_q] == dir_old_q));

   assert_miss_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (uv_q && !hit_q && !strong_q) |-> (conf_bits[ci_q] && dir_bits[ui_q] != dir_old_q));

   assert_single_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |=> ($countones(dir_bits ^ $past(dir_bits)) <= 1 &&
                     $countones(conf_bits ^ $past(conf_bits)) <= 1));

   assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |=> ($stable(dir_bits) && $stable(conf_bits)));

endmodule

bind shbp_top shbp_checker #(
   .PC_W(PC_W), .PC_LSB(PC_LSB), .DIR_ENTRIES(DIR_ENTRIES), .SHARE(SHARE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_pc(upd_pc),
   .upd_taken(upd_taken), .dir_bits(dir_bits), .conf_bits(conf_bits)
);

// File: tb/shbp_top_test.sv
`timescale 1ns/1ps
module shbp_top_test;

   localparam int PC_W = 8;
   localparam int PC_LSB = 2;
   localparam int N = 16;
   localparam int SH = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [PC_W-1:0] lk_pc = '0, upd_pc = '0;
   logic upd_valid = 1'b0, upd_taken = 1'b0;
   logic pred_taken, pred_strong;

   int checks = 0, fails = 0;
   logic done = 1'b0;
   logic dir_m [N];
   logic conf_m [N/SH];
   logic [7:0] lfsr = 8'hA5;

   always #2.5 clk = ~clk;

   shbp_top #(.PC_W(PC_W), .PC_LSB(PC_LSB), .DIR_ENTRIES(N), .SHARE(SH)) uut (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .pred_taken(pred_taken),
      .pred_strong(pred_strong), .upd_valid(upd_valid), .upd_pc(upd_pc),
      .upd_taken(upd_taken)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b (lk_pc=%h)", tag, act, exp, lk_pc);
      end
   endtask

   function automatic logic [7:0] step(input logic [7:0] v);
      return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
   endfunction

   function automatic logic [PC_W-1:0] mkpc(input int idx, input logic [7:0] r);
      return {r[7:6], 4'(idx), r[1:0]};
   endfunction

   // Look up every entry and compare with the model (R2 direction, R3 confidence)
   task automatic sweep(input string tag);
      @(negedge clk);
      upd_valid = 1'b0;
      for (int i = 0; i < N; i++) begin
         lfsr = step(lfsr);
         lk_pc = mkpc(i, lfsr);
         #0.2;
         chk({tag, " dir"}, pred_taken, dir_m[i]);
         chk({tag, " conf"}, pred_strong, conf_m[i/SH]);
      end
   endtask

   task automatic do_upd(input logic [PC_W-1:0] pc, input logic t, input logic v);
      int idx, g;
      idx = int'(pc[5:2]);
      g = idx / SH;
      @(negedge clk);
      upd_pc = pc; upd_taken = t; upd_valid = v; lk_pc = pc;
      #1;
      chk("R7 same-cycle dir", pred_taken, dir_m[idx]);
      chk("R7 same-cycle conf", pred_strong, conf_m[g]);
      @(posedge clk);
      if (v) begin
         if (dir_m[idx] == t) conf_m[g] = 1'b1;
         else if (conf_m[g]) conf_m[g] = 1'b0;
         else begin dir_m[idx] = ~dir_m[idx]; conf_m[g] = 1'b1; end
      end
   endtask

   task automatic probe(input string tag, input int idx, input logic ed, input logic ec);
      @(negedge clk);
      upd_valid = 1'b0;
      lk_pc = mkpc(idx, 8'hC3);
      #1;
      chk({tag, " dir"}, pred_taken, ed);
      chk({tag, " conf"}, pred_strong, ec);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) dir_m[i] = 1'b0;
      for (int g = 0; g < N/SH; g++) conf_m[g] = 1'b0;
      repeat (3) @(posedge clk);
      sweep("R1 in-reset");
      @(negedge clk) rst_n = 1'b1;
      sweep("R1 after-reset");

      do_upd(mkpc(0, 8'h00), 1'b1, 1'b1);
      probe("R6 flip", 0, 1'b1, 1'b1);
      probe("R8 neighbour", 1, 1'b0, 1'b1);
      probe("R8 other group", 4, 1'b0, 1'b0);
      do_upd(mkpc(0, 8'hC0), 1'b0, 1'b1);
      probe("R5 weaken", 0, 1'b1, 1'b0);
      do_upd(mkpc(0, 8'h43), 1'b1, 1'b1);
      probe("R4 confirm", 0, 1'b1, 1'b1);
      do_upd(mkpc(5, 8'h00), 1'b1, 1'b0);
      probe("R9 idle", 5, 1'b0, 1'b0);
      do_upd(mkpc(3, 8'h00), 1'b0, 1'b1);
      probe("R4 not-taken hit", 3, 1'b0, 1'b1);

      for (int k = 0; k < 3000; k++) begin
         lfsr = step(lfsr);
         do_upd(lfsr, lfsr[3] ^ lfsr[6], (k % 7) != 3);
         if (k % 16 == 15) sweep("R2/R3 model");
      end
      sweep("R2/R3 final");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule